// File: doc/BRIEF.md
# Unum Register Unpacker

This block takes one variable-size universal number (unum) as it sits in memory and spreads it into a fixed-layout register word. Later arithmetic can then find every field at a constant bit position. The field widths come from a runtime environment setting with two parts. The first is the exponent-size-size (ESS), the number of bits that hold esize-1. The second is the fraction-size-size (FSS), the number of bits that hold fsize-1. The block supports up to ESS = 4 and FSS = 5, which gives an exponent of at most 16 bits and a fraction of at most 32 bits.

Each variable-width field is right-justified in its own slot, and every bit outside the current width reads as zero. The implicit leading bit of the significand is stored explicitly as a "revealed" bit just above the fraction. Five single-bit summary flags sit in the top bits of the word. They pre-decode the following conditions, so that downstream logic can test them with a single bit instead of a wide comparison tree:

- strictly negative
- NaN
- infinity
- zero
- the other end of the interval is in the next register

If the environment setting is larger than the hardware supports, the block does not unpack. It raises a trap flag so that software can handle the value.

The unpack takes one registered cycle. A word is captured whenever `valid_in` is high, and the results appear one clock later together with `valid_out`.

Top module: `unum_unpack`

## Requirements
- R1: When a captured request has `cfg_ess` > 4 or `cfg_fss` > 5, `trap_out` is 1 and `word_out` is all zeros. Otherwise `trap_out` is 0.
- R2: `valid_out` is `valid_in` delayed by one clock. `word_out` and `trap_out` change only in the cycle after `valid_in` is high, and hold their values otherwise.
- R3: The packed input holds its fields right-justified, from the least significant bit upward, in this order:
  - fsize-1 (FSS bits)
  - esize-1 (ESS bits)
  - ubit (1 bit)
  - fraction (fsize bits)
  - exponent (esize bits)
  - sign (1 bit)
- R4: The unpacked word places its fields as follows. Unused slot bits are 0.
  - fsize-1 at [4:0]
  - esize-1 at [8:5]
  - ubit at [9]
  - fraction at [41:10]
  - exponent at [58:43]
- R5: Bit 42, the revealed bit, is 1 exactly when the exponent field is nonzero.
- R6: Bit 63, the less-than-zero flag, equals the sign bit, except that it is 0 for an exact zero (exponent 0, fraction 0, ubit 0). The raw sign has no other slot.
- R7: Bit 62, the NaN flag, is 1 when the ubit is 1 and the exponent, fraction, esize-1 and fsize-1 fields are all ones within their current widths. This holds for either sign, and the sign stays visible in bit 63.
- R8: Bit 61, the infinity flag, is 1 when the same four fields are all ones and the ubit is 0.
- R9: Bit 60, the zero flag, is 1 whenever the exponent and fraction are both zero, whatever the ubit and sign. It may be set together with bit 63.
- R10: Bit 59, the pair flag, equals `pair_in`.
- R11: Packed input bits above the sign bit have no effect on any output.
- R12: After reset, `valid_out`, `trap_out` and `word_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | Request strobe; inputs are captured at this edge |
| cfg_ess | input | 3 | Exponent-size-size of the environment |
| cfg_fss | input | 3 | Fraction-size-size of the environment |
| pair_in | input | 1 | The interval's other endpoint is in the next register |
| packed_in | input | 59 | Packed unum, right-justified |
| valid_out | output | 1 | Result valid, one cycle after the request |
| trap_out | output | 1 | The environment is too large for hardware unpacking |
| word_out | output | 64 | Unpacked word with summary flags |

## Verification
The assertions check, on every cycle, the following relations between the registered outputs:

- the one-cycle valid timing, and that the outputs hold while idle
- that a trapped word is all zeros
- that NaN and infinity are never set together
- that the revealed bit agrees with the zero flag and the infinity flag
- that a word carrying both the negative and zero flags has its ubit set

Whether each field sits at the right offset for every environment, whether the masking clears stray bits, and whether the flags fire on the exact special patterns can only be shown by the bench. The bench covers these with directed cases and with random unums checked against a reference model.

// File: rtl/unum_unpack_pkg.sv
package unum_unpack_pkg;

   // Single-bit pre-decoded attributes carried at the top of the word.
   typedef struct packed {
      logic neg;
      logic nan;
      logic inf;
      logic zero;
      logic pair;
   } summary_t;

   localparam int SUMMARY_W = $bits(summary_t);

endpackage

// File: rtl/uu_field_split.sv
// Locates the fields of a packed unum from the environment and returns
// them right-justified, with bits beyond each current width cleared.
module uu_field_split #(
   parameter int ESS_MAX  = 4,
   parameter int FSS_MAX  = 5,
   parameter int CFG_W    = 3,
   localparam int EXP_W    = 1 << ESS_MAX,
   localparam int FRAC_W   = 1 << FSS_MAX,
   localparam int PACKED_W = 2 + EXP_W + FRAC_W + ESS_MAX + FSS_MAX
) (
   input  logic [CFG_W-1:0]    cfg_ess,
   input  logic [CFG_W-1:0]    cfg_fss,
   input  logic [PACKED_W-1:0] packed_in,
   output logic [ESS_MAX-1:0]  esm1,
   output logic [FSS_MAX-1:0]  fsm1,
   output logic                ubit,
   output logic [FRAC_W-1:0]   frac,
   output logic [EXP_W-1:0]    expo,
   output logic                sign
);

   localparam int SH_W  = $clog2(PACKED_W) + 1;
   localparam int ESZ_W = ESS_MAX + 1;
   localparam int FSZ_W = FSS_MAX + 1;

   logic [PACKED_W-1:0] after_fs;
   logic [PACKED_W-1:0] after_es;
   logic [PACKED_W-1:0] after_ub;
   logic [PACKED_W-1:0] after_fr;
   logic [PACKED_W-1:0] after_ex;
   logic [ESZ_W-1:0]    esize;
   logic [FSZ_W-1:0]    fsize;

   assign after_fs = packed_in >> cfg_fss;
   assign after_es = packed_in >> (SH_W'(cfg_fss) + SH_W'(cfg_ess));
   assign after_ub = after_es >> 1;
   assign after_fr = after_ub >> fsize;
   assign after_ex = after_fr >> esize;

   assign ubit  = after_es[0];
   assign sign  = after_ex[0];
   assign esize = ESZ_W'(esm1) + ESZ_W'(1);
   assign fsize = FSZ_W'(fsm1) + FSZ_W'(1);

   // Per-bit width gates: a bit survives only below the current width.
   for (genvar i = 0; i < FSS_MAX; i++) begin : g_fsm1
      assign fsm1[i] = packed_in[i] & (CFG_W'(i) < cfg_fss);
   end

   for (genvar i = 0; i < ESS_MAX; i++) begin : g_esm1
      assign esm1[i] = after_fs[i] & (CFG_W'(i) < cfg_ess);
   end

   for (genvar i = 0; i < FRAC_W; i++) begin : g_frac
      assign frac[i] = after_ub[i] & (FSZ_W'(i) < fsize);
   end

   for (genvar i = 0; i < EXP_W; i++) begin : g_expo
      assign expo[i] = after_fr[i] & (ESZ_W'(i) < esize);
   end

endmodule

// File: rtl/uu_summary.sv
// Derives the summary flags and the revealed bit from the split fields.
module uu_summary
   import unum_unpack_pkg::*;
#(
   parameter int ESS_MAX = 4,
   parameter int FSS_MAX = 5,
   parameter int CFG_W   = 3,
   localparam int EXP_W  = 1 << ESS_MAX,
   localparam int FRAC_W = 1 << FSS_MAX
) (
   input  logic [CFG_W-1:0]   cfg_ess,
   input  logic [CFG_W-1:0]   cfg_fss,
   input  logic [ESS_MAX-1:0] esm1,
   input  logic [FSS_MAX-1:0] fsm1,
   input  logic               ubit,
   input  logic [FRAC_W-1:0]  frac,
   input  logic [EXP_W-1:0]   expo,
   input  logic               sign,
   input  logic               pair_in,
   output summary_t           flags,
   output logic               revealed
);

   localparam int ESZ_W = ESS_MAX + 1;
   localparam int FSZ_W = FSS_MAX + 1;

   logic [ESZ_W-1:0] esize;
   logic [FSZ_W-1:0] fsize;
   logic             es_full, fs_full, ex_full, fr_full;
   logic             all_ones, mag_zero;

   assign esize = ESZ_W'(esm1) + ESZ_W'(1);
   assign fsize = FSZ_W'(fsm1) + FSZ_W'(1);

   // A field of width w is all ones when adding one gives exactly 2**w.
   assign es_full = ((ESZ_W)'(esm1) + ESZ_W'(1)) == (ESZ_W'(1) << cfg_ess);
   assign fs_full = ((FSZ_W)'(fsm1) + FSZ_W'(1)) == (FSZ_W'(1) << cfg_fss);
   assign ex_full = ({1'b0, expo} + (EXP_W+1)'(1)) == ((EXP_W+1)'(1) << esize);
   assign fr_full = ({1'b0, frac} + (FRAC_W+1)'(1)) == ((FRAC_W+1)'(1) << fsize);

   assign all_ones = es_full & fs_full & ex_full & fr_full;
   assign mag_zero = ~|expo & ~|frac;

   assign flags.nan  = all_ones & ubit;
   assign flags.inf  = all_ones & ~ubit;
   assign flags.zero = mag_zero;
   assign flags.neg  = sign & ~(mag_zero & ~ubit);
   assign flags.pair = pair_in;
   assign revealed   = ~mag_zero & |expo;

endmodule

// File: rtl/unum_unpack.sv
// Unpacks a packed unum into a fixed 64-bit-class register word in one cycle.
module unum_unpack
   import unum_unpack_pkg::*;
#(
   parameter int ESS_MAX  = 4,
   parameter int FSS_MAX  = 5,
   parameter int CFG_W    = 3,
   localparam int EXP_W    = 1 << ESS_MAX,
   localparam int FRAC_W   = 1 << FSS_MAX,
   localparam int PACKED_W = 2 + EXP_W + FRAC_W + ESS_MAX + FSS_MAX,
   localparam int WORD_W   = PACKED_W + SUMMARY_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid_in,
   input  logic [CFG_W-1:0]    cfg_ess,
   input  logic [CFG_W-1:0]    cfg_fss,
   input  logic                pair_in,
   input  logic [PACKED_W-1:0] packed_in,
   output logic                valid_out,
   output logic                trap_out,
   output logic [WORD_W-1:0]   word_out
);

   // Word layout, low to high.
   localparam int UB_POS   = FSS_MAX + ESS_MAX;
   localparam int FR_LO    = UB_POS + 1;
   localparam int HID_POS  = FR_LO + FRAC_W;
   localparam int EX_LO    = HID_POS + 1;
   localparam int PAIR_POS = EX_LO + EXP_W;
   localparam int ZERO_POS = PAIR_POS + 1;
   localparam int INF_POS  = PAIR_POS + 2;
   localparam int NAN_POS  = PAIR_POS + 3;
   localparam int NEG_POS  = PAIR_POS + 4;

   // Elaboration-time parameter checks.
   if (ESS_MAX < 1 || FSS_MAX < 1) begin : g_bad_min
      $error("unum_unpack: ESS_MAX and FSS_MAX must be at least 1");
   end
   if (ESS_MAX > (1 << CFG_W) - 1 || FSS_MAX > (1 << CFG_W) - 1) begin : g_bad_cfg
      $error("unum_unpack: CFG_W too narrow for the supported environment");
   end
   if (NEG_POS != WORD_W - 1) begin : g_bad_layout
      $error("unum_unpack: word layout does not fill the word");
   end

   logic [ESS_MAX-1:0] esm1;
   logic [FSS_MAX-1:0] fsm1;
   logic               ubit, sign, revealed, trap_n;
   logic [FRAC_W-1:0]  frac;
   logic [EXP_W-1:0]   expo;
   summary_t           flags;
   logic [WORD_W-1:0]  word_n;

   uu_field_split #(
      .ESS_MAX (ESS_MAX),
      .FSS_MAX (FSS_MAX),
      .CFG_W   (CFG_W)
   ) u_split (
      .cfg_ess   (cfg_ess),
      .cfg_fss   (cfg_fss),
      .packed_in (packed_in),
      .esm1      (esm1),
      .fsm1      (fsm1),
      .ubit      (ubit),
      .frac      (frac),
      .expo      (expo),
      .sign      (sign)
   );

   uu_summary #(
      .ESS_MAX (ESS_MAX),
      .FSS_MAX (FSS_MAX),
      .CFG_W   (CFG_W)
   ) u_summary (
      .cfg_ess  (cfg_ess),
      .cfg_fss  (cfg_fss),
      .esm1     (esm1),
      .fsm1     (fsm1),
      .ubit     (ubit),
      .frac     (frac),
      .expo     (expo),
      .sign     (sign),
      .pair_in  (pair_in),
      .flags    (flags),
      .revealed (revealed)
   );

   assign trap_n = (cfg_ess > CFG_W'(ESS_MAX)) || (cfg_fss > CFG_W'(FSS_MAX));
   assign word_n = trap_n ? '0
                          : {flags, expo, revealed, frac, ubit, esm1, fsm1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         trap_out  <= 1'b0;
         word_out  <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            trap_out <= trap_n;
            word_out <= word_n;
         end
      end
   end

   // R2: result strobe one cycle after the request
   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);

   // R2: outputs hold when no request arrives
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> (!valid_out && $stable(word_out) && $stable(trap_out)));

   // R1: an oversized environment always traps
   p_trap_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && (cfg_ess > CFG_W'(ESS_MAX) || cfg_fss > CFG_W'(FSS_MAX)))
      |=> trap_out);

   // R1: a trapped word carries nothing
   p_trap_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      trap_out |-> (word_out == '0));

   // R7 / R8: NaN and infinity are mutually exclusive
   p_nan_inf_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(word_out[NAN_POS] && word_out[INF_POS]));

   // R5 / R9: a zero magnitude has no revealed bit
   p_zero_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
      word_out[ZERO_POS] |-> !word_out[HID_POS]);

   // R8: infinity has a nonzero exponent
   p_inf_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
      word_out[INF_POS] |-> word_out[HID_POS]);

   // R6: a negative zero flag pair only for an inexact zero
   p_neg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_out[NEG_POS] && word_out[ZERO_POS]) |-> word_out[UB_POS]);

endmodule

// File: tb/unum_unpack_test.sv
`timescale 1ns/1ps
module unum_unpack_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [2:0]  cfg_ess = '0;
   logic [2:0]  cfg_fss = '0;
   logic        pair_in = 1'b0;
   logic [58:0] packed_in = '0;
   logic        valid_out, trap_out;
   logic [63:0] word_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   unum_unpack uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_in  (valid_in),
      .cfg_ess   (cfg_ess),
      .cfg_fss   (cfg_fss),
      .pair_in   (pair_in),
      .packed_in (packed_in),
      .valid_out (valid_out),
      .trap_out  (trap_out),
      .word_out  (word_out)
   );

   // Builds a packed unum from its fields (layout per R3).
   function automatic logic [58:0] pk_build(int ess, int fss, bit sgn,
         longint ex, longint fr, bit ub, int esm1, int fsm1);
      logic [58:0] r = '0;
      int p = 0;
      for (int i = 0; i < fss; i++) r[p+i] = fsm1[i];
      p += fss;
      for (int i = 0; i < ess; i++) r[p+i] = esm1[i];
      p += ess;
      r[p] = ub;
      p += 1;
      for (int i = 0; i <= fsm1; i++) r[p+i] = fr[i];
      p += fsm1 + 1;
      for (int i = 0; i <= esm1; i++) r[p+i] = ex[i];
      p += esm1 + 1;
      r[p] = sgn;
      return r;
   endfunction

   // Reference unpack from the requirements.
   function automatic logic [63:0] ref_word(int ess, int fss, bit pr,
         logic [58:0] pk, output bit tr);
      logic [63:0] w = '0;
      int p = 0;
      int fsm1 = 0, esm1 = 0;
      longint ex = 0, fr = 0;
      bit ub, sgn, ones, zero;
      tr = (ess > 4) || (fss > 5);
      if (tr) return '0;
      for (int i = 0; i < fss; i++) fsm1 |= int'(pk[p+i]) << i;
      p += fss;
      for (int i = 0; i < ess; i++) esm1 |= int'(pk[p+i]) << i;
      p += ess;
      ub = pk[p];
      p += 1;
      for (int i = 0; i <= fsm1; i++) fr |= longint'(pk[p+i]) << i;
      p += fsm1 + 1;
      for (int i = 0; i <= esm1; i++) ex |= longint'(pk[p+i]) << i;
      p += esm1 + 1;
      sgn = pk[p];
      ones = (fsm1 == (1 << fss) - 1) && (esm1 == (1 << ess) - 1) &&
             (fr == (longint'(1) << (fsm1 + 1)) - 1) &&
             (ex == (longint'(1) << (esm1 + 1)) - 1);
      zero = (ex == 0) && (fr == 0);
      w[4:0]   = 5'(fsm1);
      w[8:5]   = 4'(esm1);
      w[9]     = ub;
      w[41:10] = 32'(fr);
      w[42]    = (ex != 0);
      w[58:43] = 16'(ex);
      w[59]    = pr;
      w[60]    = zero;
      w[61]    = ones && !ub;
      w[62]    = ones && ub;
      w[63]    = sgn && !(zero && !ub);
      return w;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One request; checks result cycle and the following idle cycle.
   task automatic txn(string req, int ess, int fss, bit pr, logic [58:0] pk);
      logic [63:0] w_exp;
      bit t_exp;
      w_exp = ref_word(ess, fss, pr, pk, t_exp);
      valid_in  = 1'b1;
      cfg_ess   = 3'(ess);
      cfg_fss   = 3'(fss);
      pair_in   = pr;
      packed_in = pk;
      @(negedge clk);
      valid_in  = 1'b0;
      chk({req, " R2 valid"}, 64'(valid_out), 64'd1);
      chk({req, " R1 trap"}, 64'(trap_out), 64'(t_exp));
      chk({req, " word"}, word_out, w_exp);
      // Scramble inputs while idle: nothing may move (R2).
      cfg_ess   = 3'($urandom);
      pair_in   = ~pr;
      packed_in = {$urandom, $urandom};
      @(negedge clk);
      chk({req, " R2 idle valid"}, 64'(valid_out), 64'd0);
      chk({req, " R2 idle hold"}, word_out, w_exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [58:0] pk;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 reset valid", 64'(valid_out), 64'd0);
      chk("R12 reset trap", 64'(trap_out), 64'd0);
      chk("R12 reset word", word_out, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 / R6: exact zero with sign set -> zero flag, no negative flag
      txn("R9 exact neg zero", 3, 4, 1'b0, pk_build(3, 4, 1, 0, 0, 0, 5, 9));
      chk("R6 exact zero not negative", 64'(word_out[63]), 64'd0);
      // R9 / R6: inexact zero on the negative side -> both flags
      txn("R9 inexact neg zero", 2, 3, 1'b1, pk_build(2, 3, 1, 0, 0, 1, 1, 2));
      chk("R6 inexact neg zero", {62'd0, word_out[63], word_out[60]}, 64'd3);
      chk("R10 pair flag", 64'(word_out[59]), 64'd1);
      // R8: positive and negative infinity at the largest environment
      txn("R8 pos inf", 4, 5, 1'b0,
          pk_build(4, 5, 0, 64'hFFFF, 64'hFFFF_FFFF, 0, 15, 31));
      chk("R8 inf flag", {61'd0, word_out[63:61]}, 64'b001);
      txn("R8 neg inf", 4, 5, 1'b0,
          pk_build(4, 5, 1, 64'hFFFF, 64'hFFFF_FFFF, 0, 15, 31));
      chk("R8 neg inf flags", {61'd0, word_out[63:61]}, 64'b101);
      // R7: quiet and signalling NaN in a small environment
      txn("R7 quiet nan", 1, 1, 1'b0, pk_build(1, 1, 0, 3, 3, 1, 1, 1));
      chk("R7 nan flag", {61'd0, word_out[63:61]}, 64'b010);
      txn("R7 signal nan", 1, 1, 1'b0, pk_build(1, 1, 1, 3, 3, 1, 1, 1));
      chk("R7 nan sign kept", {61'd0, word_out[63:61]}, 64'b110);
      // R8: all-ones fields but sizes not at maximum -> not infinity
      txn("R8 not max size", 2, 2, 1'b0, pk_build(2, 2, 0, 3, 7, 0, 1, 2));
      chk("R8 no inf", 64'(word_out[61]), 64'd0);
      // R5: subnormal has revealed bit clear, normal has it set
      txn("R5 subnormal", 0, 0, 1'b0, pk_build(0, 0, 0, 0, 1, 0, 0, 0));
      chk("R5 revealed clear", 64'(word_out[42]), 64'd0);
      txn("R5 normal", 0, 0, 1'b0, pk_build(0, 0, 0, 1, 0, 0, 0, 0));
      chk("R5 revealed set", 64'(word_out[42]), 64'd1);
      // R4: field placement at the widest environment
      txn("R4 layout", 4, 5, 1'b0,
          pk_build(4, 5, 0, 64'h8001, 64'h8000_0001, 1, 15, 31));
      chk("R4 exponent slot", 64'(word_out[58:43]), 64'h8001);
      chk("R4 fraction slot", 64'(word_out[41:10]), 64'h8000_0001);
      // R11: garbage above the sign bit
      pk = pk_build(1, 2, 0, 2, 5, 0, 1, 3);
      pk[58:14] = '1;
      pk[13] = 1'b0;
      txn("R11 upper junk", 1, 2, 1'b0, pk);
      chk("R11 sign unaffected", 64'(word_out[63]), 64'd0);
      // R1: oversized environments
      txn("R1 trap ess", 5, 2, 1'b1, 59'h7_1234_5678);
      txn("R1 trap fss", 2, 6, 1'b0, 59'h1_FFFF);
      txn("R1 trap both", 7, 7, 1'b1, '1);

      // R3 / R4 / R6-R10: random unums against the reference
      for (int n = 0; n < 400; n++) begin
         int e, f;
         e = int'($urandom_range(0, 4));
         f = int'($urandom_range(0, 5));
         if ($urandom_range(0, 15) == 0) e = int'($urandom_range(5, 7));
         if ($urandom_range(0, 15) == 0) f = int'($urandom_range(6, 7));
         txn("R3 random", e, f, 1'($urandom), {$urandom, $urandom});
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule